// File: doc/BRIEF.md
# Power-on reset pulse generator

This block produces the system reset for a processor. It watches two conditions: a synchronous flag that is high while the supply is above its threshold, and an active-low manual-reset input. The manual input may come from a pushbutton or from a logic driver. Either condition holds the reset active. Once both conditions clear, the reset stays active for a fixed stretch and then releases. A new trigger during that stretch starts the full stretch again.

The manual input is asynchronous and may bounce, so it passes through a two-flop synchroniser. A debouncer then accepts a new level only after that level has been stable for a set number of cycles. A watchdog can force a reset only by driving the manual input. The block drives two outputs: an active-low reset and its active-high complement. Both come from one register, so they are always consistent.

Top module: `por_reset_gen`

## Requirements
- R1: While `supplyOk` is sampled low at a rising edge, `rstN` is low after that edge, and it stays low for as long as `supplyOk` stays low.
- R2: A low level on `manRstN` that is accepted by the debouncer drives `rstN` low. With no bouncing, `rstN` falls after the (DEBOUNCE_CYCLES+3)-th rising edge that samples the low level.
- R3: After the last edge at which any trigger is active, `rstN` stays low through the next STRETCH_CYCLES-1 rising edges. It rises after the STRETCH_CYCLES-th edge.
- R4: `rst` is at all times the exact inverse of `rstN`.
- R5: A new `manRstN` level takes effect only after the synchronised input has differed from the accepted level on DEBOUNCE_CYCLES consecutive edges. Shorter pulses and bounces leave `rstN` unchanged.
- R6: From power-up, `rstN` is low from the first clock. With no trigger present, it rises after the STRETCH_CYCLES-th rising edge.
- R7: A trigger that arrives while the stretch is running restarts it. The release then takes a full STRETCH_CYCLES edges after that trigger clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| supplyOk | input | 1 | Synchronous flag, high while the supply is above threshold |
| manRstN | input | 1 | Asynchronous active-low manual reset; may bounce |
| rstN | output | 1 | Active-low system reset |
| rst | output | 1 | Active-high system reset, inverse of `rstN` |

## Verification
Two functions of this block can fall in the same cycle.

The first case is a retrigger that lands on the very last cycle of a stretch. The bench drops `supplyOk` exactly on the edge where the counter would otherwise release. The expected result is that the reset stays low and a full stretch starts again; an early release would show the wrong cycle. The second case is the supply recovering on the same cycle as the manual input is released. Here the stretch must count from the later of the two conditions to clear, which is the debounced manual level. A behavioural model in the bench computes the expected reset on every clock, and the outputs are compared with it at every falling edge.

// File: rtl/porgen_pkg.sv
package porgen_pkg;
  typedef struct packed {
    logic dbClr;
    logic dbInc;
    logic stClr;
    logic stInc;
  } strobe_t;
endpackage

// File: rtl/porgen_dp.sv
module porgen_dp
  import porgen_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1000000,
  parameter int STRETCH_CYCLES  = 10000000
) (
  input  logic    clk,
  input  logic    manRstN,
  input  strobe_t strb,
  output logic    syncMan,
  output logic    dbDone,
  output logic    stDone
);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);

  logic          sync1 = 1'b1;
  logic          sync2 = 1'b1;
  logic [DW-1:0] dbCnt = '0;
  logic [SW-1:0] stCnt = '0;
  logic          live  = 1'b0;

  always_ff @(posedge clk) begin
    live  <= 1'b1;
    sync1 <= manRstN;
    sync2 <= sync1;
    if (strb.dbClr)      dbCnt <= '0;
    else if (strb.dbInc) dbCnt <= dbCnt + 1'b1;
    if (strb.stClr)      stCnt <= '0;
    else if (strb.stInc) stCnt <= stCnt + 1'b1;
  end

  assign syncMan = sync2;
  assign dbDone  = (dbCnt == DW'(DEBOUNCE_CYCLES - 1));
  assign stDone  = (stCnt == SW'(STRETCH_CYCLES - 1));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!live)
    strb.stClr |=> (stCnt == '0));

  // R5
  db_range_chk: assert property (@(posedge clk) disable iff (!live)
    dbCnt <= DW'(DEBOUNCE_CYCLES - 1));
endmodule

// File: rtl/porgen_ctrl.sv
module porgen_ctrl
  import porgen_pkg::*;
(
  input  logic    clk,
  input  logic    supplyOk,
  input  logic    syncMan,
  input  logic    dbDone,
  input  logic    stDone,
  output strobe_t strb,
  output logic    holding
);
  logic dbLevel = 1'b1;
  logic holdQ   = 1'b1;
  logic live    = 1'b0;
  logic differ;
  logic trig;

  always_comb begin
    differ     = (syncMan != dbLevel);
    trig       = !supplyOk || !dbLevel;
    strb.dbClr = !differ || dbDone;
    strb.dbInc = differ && !dbDone;
    strb.stClr = trig || !holdQ;
    strb.stInc = !trig && holdQ && !stDone;
  end

  always_ff @(posedge clk) begin
    live <= 1'b1;
    if (differ && dbDone) dbLevel <= syncMan;
    if (trig)                 holdQ <= 1'b1;
    else if (holdQ && stDone) holdQ <= 1'b0;
  end

  assign holding = holdQ;

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (!live)
    !supplyOk |=> holding);

  // R2
  manual_hold_chk: assert property (@(posedge clk) disable iff (!live)
    !dbLevel |=> holding);

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!live)
    $fell(holding) |-> ($past(stDone) && $past(supplyOk) && $past(dbLevel)));

  // R5
  debounce_chk: assert property (@(posedge clk) disable iff (!live)
    (dbLevel != $past(dbLevel)) |-> ($past(dbDone) && ($past(syncMan) == dbLevel)));
endmodule

// File: rtl/por_reset_gen.sv
module por_reset_gen
  import porgen_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1000000,
  parameter int STRETCH_CYCLES  = 10000000
) (
  input  logic clk,
  input  logic supplyOk,
  input  logic manRstN,
  output logic rstN,
  output logic rst
);
  strobe_t strb;
  logic    syncMan;
  logic    dbDone;
  logic    stDone;
  logic    holding;

  porgen_dp #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .STRETCH_CYCLES (STRETCH_CYCLES)
  ) uDp (
    .clk    (clk),
    .manRstN(manRstN),
    .strb   (strb),
    .syncMan(syncMan),
    .dbDone (dbDone),
    .stDone (stDone)
  );

  porgen_ctrl uCtrl (
    .clk     (clk),
    .supplyOk(supplyOk),
    .syncMan (syncMan),
    .dbDone  (dbDone),
    .stDone  (stDone),
    .strb    (strb),
    .holding (holding)
  );

  assign rstN = !holding;
  assign rst  = holding;
endmodule

// File: tb/sim_por_reset_gen.sv
`timescale 1ns/1ps
module sim_por_reset_gen;
  localparam int DEB = 4;
  localparam int STR = 20;

  logic clk = 1'b0;
  logic supplyOk = 1'b1;
  logic manRstN = 1'b1;
  logic rstN;
  logic rst;

  always #2.5 clk = ~clk;

  por_reset_gen #(.DEBOUNCE_CYCLES(DEB), .STRETCH_CYCLES(STR)) u0 (
    .clk(clk), .supplyOk(supplyOk), .manRstN(manRstN), .rstN(rstN), .rst(rst)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  string curReq = "R6";

  // behavioural reference
  bit mQ[$] = '{1'b1, 1'b1};
  int runLen = 0;
  bit lvl = 1'b1;
  bit holdM = 1'b1;
  int rem = STR;

  always @(posedge clk) begin
    bit synced;
    bit trig;
    synced = mQ[0];
    mQ.push_back(manRstN);
    void'(mQ.pop_front());
    trig = !supplyOk || !lvl;
    if (synced != lvl) begin
      runLen++;
      if (runLen == DEB) begin lvl = synced; runLen = 0; end
    end else runLen = 0;
    if (trig) begin holdM = 1'b1; rem = STR; end
    else if (holdM) begin
      rem--;
      if (rem == 0) holdM = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(rstN === !holdM, curReq, int'(rstN), int'(!holdM));
    chk(rst === !rstN, "R4", int'(rst), int'(!rstN));
    if (cyc > 5000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 5000);
      finishRun();
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R6: power-up stretch
    waitN(2);
    chk(rstN === 1'b0, "R6", int'(rstN), 0);
    waitN(STR + 3);
    chk(rstN === 1'b1, "R6", int'(rstN), 1);
    // R1 / R3: supply drop and recovery
    curReq = "R1"; supplyOk = 1'b0; waitN(6);
    chk(rstN === 1'b0, "R1", int'(rstN), 0);
    curReq = "R3"; supplyOk = 1'b1; waitN(STR + 5);
    // R2: clean manual press
    curReq = "R2"; manRstN = 1'b0; waitN(12);
    chk(rstN === 1'b0, "R2", int'(rstN), 0);
    curReq = "R5"; manRstN = 1'b1; waitN(STR + 12);
    // R5: short glitches are ignored
    for (int g = 1; g < DEB; g++) begin
      manRstN = 1'b0; waitN(g);
      manRstN = 1'b1; waitN(8);
      chk(rstN === 1'b1, "R5", int'(rstN), 1);
    end
    // R5: bouncing press then steady low
    for (int b = 0; b < 6; b++) begin manRstN = b[0]; waitN(1); end
    manRstN = 1'b0; waitN(12);
    for (int b = 0; b < 5; b++) begin manRstN = !b[0]; waitN(1); end
    manRstN = 1'b1; waitN(STR + 12);
    // R7: retrigger mid-stretch
    curReq = "R7"; supplyOk = 1'b0; waitN(2);
    supplyOk = 1'b1; waitN(10);
    supplyOk = 1'b0; waitN(2);
    supplyOk = 1'b1; waitN(STR - 1);
    supplyOk = 1'b0; waitN(1);
    supplyOk = 1'b1; waitN(STR + 4);
    // R3: supply recovery and manual release in the same cycle
    curReq = "R3"; supplyOk = 1'b0; manRstN = 1'b0; waitN(12);
    supplyOk = 1'b1; manRstN = 1'b1; waitN(STR + 10);
    chk(rstN === 1'b1, "R3", int'(rstN), 1);
    finishRun();
  end
endmodule